// File: doc/BRIEF.md
# Boolean Formula Branch Predictor

This block predicts the direction of a conditional branch without any prediction table. Each branch instruction carries a small formula field, chosen offline by profiling, that describes a monotone read-once Boolean function over recent branch outcomes. The block keeps a global shift register of the last `HIST_LEN` resolved outcomes. Those bits feed the leaves of a fixed, balanced binary tree of two-input gates. The formula field decides, gate by gate, whether each gate is an AND or an OR. The root of the tree is the prediction.

The prediction is combinational from the formula input and the stored history, so a fetch stage gets its answer in the cycle it presents the field. The resolve stage pulses an update with the real outcome, and that outcome enters the history. Because every history bit feeds exactly one leaf and nothing is inverted, the field needs only `HIST_LEN - 1` gate bits. The field is `HIST_LEN` bits wide and its top bit is spare. History lengths of 8 and 16 are both supported through the parameter.

Top module: `bfp_predictor`

## Requirements
- R1: Bit k of the formula field, for k from 0 to HIST_LEN-2, sets the type of gate k in breadth-first order: bit 0 is the root, bits 1 and 2 are its left and right children, and so on. The value 1 means OR and 0 means AND. History bit j drives leaf j+1, counting from the left, so history bit 0 is the leftmost leaf.
- R2: The top bit of the formula field (bit HIST_LEN-1) has no effect on the prediction.
- R3: When the update-valid input is high at a rising clock edge, the history shifts one place toward its MSB. The resolved outcome enters bit 0 and the oldest bit is dropped.
- R4: When update-valid is low at a rising clock edge, the history keeps its value.
- R5: The active-low asynchronous reset clears the history to all zeros, so the prediction is not-taken for every formula.
- R6: The prediction depends only on the current formula input and the stored history. An update in the same cycle changes only the prediction of later cycles.
- R7: With all gate bits 0, the prediction equals the AND of all history bits.
- R8: With all gate bits 1, the prediction equals the OR of all history bits.
- R9: For any formula, an all-ones history predicts taken and an all-zeros history predicts not-taken.
- R10: The same behaviour holds for HIST_LEN values of 8 and 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| formula | input | HIST_LEN | Formula field of the branch being predicted: gate-type bits in [HIST_LEN-2:0], spare bit on top |
| predTaken | output | 1 | Prediction, 1 = taken |
| updValid | input | 1 | Resolved-outcome strobe |
| updTaken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The hardest state to reach is a history that holds one chosen pattern under one chosen formula. Leaf order and gate placement only show when one subtree is saturated and its sibling is not, and the bench cannot write the history directly. It builds such histories by feeding a known run of outcomes through the update port. It then steps through formulas that tell the left subtree from the right. It also drives an update in the same cycle as a prediction to show that the new outcome stays invisible until the next cycle. Long random runs, interleaved with the all-AND and all-OR formulas, are checked against a behavioural level-by-level evaluator.

// File: rtl/bfp_pkg.sv
package bfp_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;   // advance the history this edge
    logic shiftBit;  // outcome shifted into bit 0
  } bfpStrobeT;

  // Number of gate levels above the leaves
  function automatic int treeLevels(input int leaves);
    int lv;
    lv = 0;
    while ((1 << lv) < leaves) lv++;
    return lv;
  endfunction

endpackage

// File: rtl/bfp_ctrl.sv
module bfp_ctrl
  import bfp_pkg::*;
(
  input  logic      updValid,
  input  logic      updTaken,
  output bfpStrobeT strobe
);

  // The outcome bit is qualified so an idle taken input never leaks in
  always_comb begin
    strobe.shiftEn  = updValid;
    strobe.shiftBit = updValid & updTaken;
  end

endmodule

// File: rtl/bfp_gate_tree.sv
module bfp_gate_tree #(
  parameter int LEAVES = 8
) (
  input  logic [LEAVES-2:0] gateSel,  // breadth-first from root, 1 = OR
  input  logic [LEAVES-1:0] leaves,   // bit 0 is leftmost leaf
  output logic              result
);

  localparam int LEVELS = bfp_pkg::treeLevels(LEAVES);

  // Level s holds LEAVES >> s values; level 0 is the leaves, level LEVELS the root.
  // Gates at level s occupy breadth-first indices (W-1) .. (2W-2), W = LEAVES >> s.
  for (genvar s = 0; s <= LEVELS; s++) begin : g_lvl
    localparam int W = LEAVES >> s;
    logic [W-1:0] vals;
    if (s == 0) begin : g_leaf
      assign vals = leaves;
    end else begin : g_gate
      for (genvar j = 0; j < W; j++) begin : g_node
        logic lhs, rhs;
        assign lhs = g_lvl[s-1].vals[2*j];
        assign rhs = g_lvl[s-1].vals[2*j+1];
        assign vals[j] = gateSel[W-1+j] ? (lhs | rhs) : (lhs & rhs);
      end
    end
  end

  assign result = g_lvl[LEVELS].vals[0];

endmodule

// File: rtl/bfp_datapath.sv
module bfp_datapath
  import bfp_pkg::*;
#(
  parameter int HIST_LEN = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  bfpStrobeT           strobe,
  input  logic [HIST_LEN-1:0] formula,
  output logic [HIST_LEN-1:0] histQ,
  output logic                predTaken
);

  localparam int GATES = HIST_LEN - 1;

  logic [GATES-1:0] gateSel;
  logic             unusedSpareBit;

  assign gateSel        = formula[GATES-1:0];
  assign unusedSpareBit = formula[HIST_LEN-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histQ <= '0;
    end else if (strobe.shiftEn) begin
      histQ <= {histQ[HIST_LEN-2:0], strobe.shiftBit};
    end
  end

  bfp_gate_tree #(.LEAVES(HIST_LEN)) u_tree (
    .gateSel (gateSel),
    .leaves  (histQ),
    .result  (predTaken)
  );

endmodule

// File: rtl/bfp_predictor.sv
module bfp_predictor
  import bfp_pkg::*;
#(
  parameter int HIST_LEN = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [HIST_LEN-1:0] formula,
  output logic                predTaken,
  input  logic                updValid,
  input  logic                updTaken
);

  bfpStrobeT           strobe;
  logic [HIST_LEN-1:0] histQ;

  bfp_ctrl u_ctrl (
    .updValid (updValid),
    .updTaken (updTaken),
    .strobe   (strobe)
  );

  bfp_datapath #(.HIST_LEN(HIST_LEN)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .formula   (formula),
    .histQ     (histQ),
    .predTaken (predTaken)
  );

endmodule

// File: rtl/bfp_checker.sv
module bfp_checker #(
  parameter int HIST_LEN = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [HIST_LEN-1:0] formula,
  input logic                predTaken,
  input logic                updValid,
  input logic                updTaken,
  input logic [HIST_LEN-1:0] histQ
);

  localparam int HALF = HIST_LEN / 2;
  localparam logic [HIST_LEN-2:0] ROOT_OR_ONLY = {{(HIST_LEN-2){1'b0}}, 1'b1};

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (histQ == '0));  // R5

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> (histQ == {$past(histQ[HIST_LEN-2:0]), $past(updTaken)}));  // R3

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> $stable(histQ));  // R4

  AST_ALL_AND: assert property (@(posedge clk) disable iff (!rstN)
    (formula[HIST_LEN-2:0] == '0) |-> (predTaken == (&histQ)));  // R7

  AST_ALL_OR: assert property (@(posedge clk) disable iff (!rstN)
    (formula[HIST_LEN-2:0] == '1) |-> (predTaken == (|histQ)));  // R8

  AST_ROOT_SPLIT: assert property (@(posedge clk) disable iff (!rstN)
    (formula[HIST_LEN-2:0] == ROOT_OR_ONLY)
      |-> (predTaken == ((&histQ[HALF-1:0]) | (&histQ[HIST_LEN-1:HALF]))));  // R1

  AST_MONO_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (&histQ) |-> predTaken);  // R9

  AST_MONO_ZEROS: assert property (@(posedge clk) disable iff (!rstN)
    (histQ == '0) |-> !predTaken);  // R9

endmodule

bind bfp_predictor bfp_checker #(.HIST_LEN(HIST_LEN)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .formula   (formula),
  .predTaken (predTaken),
  .updValid  (updValid),
  .updTaken  (updTaken),
  .histQ     (histQ)
);

// File: tb/bfp_predictor_tb.sv
module bfp_predictor_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  formula8 = '0;
  logic [15:0] formula16 = '0;
  logic        updValid = 1'b0;
  logic        updTaken = 1'b0;
  logic        predTaken8, predTaken16;

  logic [7:0]  mHist8 = '0;
  logic [15:0] mHist16 = '0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bfp_predictor #(.HIST_LEN(8)) u_dut (
    .clk(clk), .rstN(rstN), .formula(formula8), .predTaken(predTaken8),
    .updValid(updValid), .updTaken(updTaken)
  );

  bfp_predictor #(.HIST_LEN(16)) u_dut16 (
    .clk(clk), .rstN(rstN), .formula(formula16), .predTaken(predTaken16),
    .updValid(updValid), .updTaken(updTaken)
  );

  // Behavioural evaluator: reduce pairs level by level from the leaves
  function automatic logic refEval(input logic [15:0] f, input logic [15:0] h, input int n);
    int cur[16];
    int w;
    for (int j = 0; j < n; j++) cur[j] = int'(h[j]);
    w = n;
    while (w > 1) begin
      w = w / 2;
      for (int j = 0; j < w; j++)
        cur[j] = f[w-1+j] ? (cur[2*j] | cur[2*j+1]) : (cur[2*j] & cur[2*j+1]);
    end
    return cur[0] != 0;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Called just after a falling edge with inputs already set
  task automatic step(input string req);
    #1;
    check(req, predTaken8, refEval({8'h00, formula8}, {8'h00, mHist8}, 8));
    check("R10", predTaken16, refEval(formula16, mHist16, 16));
    @(posedge clk);
    if (rstN && updValid) begin
      mHist8  = {mHist8[6:0], updTaken};
      mHist16 = {mHist16[14:0], updTaken};
    end
    @(negedge clk);
  endtask

  task automatic push(input logic t);
    updValid = 1'b1; updTaken = t;
    step("R3");
    updValid = 1'b0; updTaken = 1'b0;
  endtask

  string lbl;

  initial begin
    // R5: reset holds history at zero, so even all-OR predicts not-taken
    formula8 = 8'hFF; formula16 = 16'hFFFF;
    updValid = 1'b1; updTaken = 1'b1;
    @(negedge clk); @(negedge clk);
    #1;
    check("R5", predTaken8, 1'b0);
    check("R5", predTaken16, 1'b0);
    @(negedge clk);
    updValid = 1'b0; updTaken = 1'b0;
    rstN = 1'b1;
    for (int i = 0; i < 4; i++) begin
      formula8 = 8'($urandom); formula16 = 16'($urandom);
      #1;
      check("R5", predTaken8, 1'b0);
      step("R5");
    end

    // R1: build history 0x0F (x1..x4 set) and probe leaf order
    for (int i = 0; i < 4; i++) push(1'b1);
    formula8 = 8'h01; formula16 = 16'h0001; #1;
    check("R1", predTaken8, 1'b1);           // left subtree all AND, saturated
    formula8 = 8'h02; #1;
    check("R1", predTaken8, 1'b0);           // root AND with unsaturated right
    formula8 = 8'h03; #1;
    check("R1", predTaken8, 1'b1);
    step("R1");

    // R6: same-cycle update does not move the current prediction
    formula8 = 8'h00; formula16 = 16'h0000;
    updValid = 1'b1; updTaken = 1'b1;
    #1;
    check("R6", predTaken8, 1'b0);
    step("R6");
    updValid = 1'b0;
    updValid = 1'b1; updTaken = 1'b1;
    step("R6");
    updValid = 1'b0; updTaken = 1'b0;
    // history now 0x3F: six ones
    for (int i = 0; i < 2; i++) push(1'b1); // 0xFF
    formula8 = 8'h00; #1;
    check("R7", predTaken8, 1'b1);
    step("R7");
    for (int i = 0; i < 4; i++) push(1'b0); // 0xF0
    formula8 = 8'h01; #1;
    check("R1", predTaken8, 1'b1);           // right subtree saturated
    formula8 = 8'h02; #1;
    check("R1", predTaken8, 1'b0);
    formula8 = 8'h04; #1;
    check("R1", predTaken8, 1'b0);           // root AND, left subtree empty
    step("R1");

    // R2: spare top bit toggled must not move the prediction
    for (int i = 0; i < 20; i++) begin
      logic a8, a16;
      formula8 = 8'($urandom); formula16 = 16'($urandom);
      #1; a8 = predTaken8; a16 = predTaken16;
      formula8[7] = ~formula8[7]; formula16[15] = ~formula16[15];
      #1;
      check("R2", predTaken8, a8);
      check("R2", predTaken16, a16);
      updValid = 1'($urandom); updTaken = 1'($urandom);
      step("R2");
    end
    updValid = 1'b0;

    // R9: saturate history both ways
    for (int i = 0; i < 16; i++) push(1'b1);
    for (int i = 0; i < 6; i++) begin
      formula8 = 8'($urandom); formula16 = 16'($urandom); #1;
      check("R9", predTaken8, 1'b1);
      check("R9", predTaken16, 1'b1);
      step("R9");
    end
    for (int i = 0; i < 16; i++) push(1'b0);
    for (int i = 0; i < 6; i++) begin
      formula8 = 8'($urandom); formula16 = 16'($urandom); #1;
      check("R9", predTaken8, 1'b0);
      check("R9", predTaken16, 1'b0);
      step("R9");
    end

    // Random phase with forced all-AND / all-OR formulas
    for (int i = 0; i < 3000; i++) begin
      case (i % 6)
        0: begin formula8 = {1'($urandom), 7'h00}; formula16 = {1'($urandom), 15'h0000}; lbl = "R7"; end
        3: begin formula8 = {1'($urandom), 7'h7F}; formula16 = {1'($urandom), 15'h7FFF}; lbl = "R8"; end
        default: begin formula8 = 8'($urandom); formula16 = 16'($urandom); lbl = "R4"; end
      endcase
      if (lbl == "R4" && updValid) lbl = "R3";
      updValid = (($urandom % 4) != 0);
      updTaken = (($urandom % 3) != 0);
      if (i % 6 == 0) begin #1; check("R7", predTaken8, &mHist8); end
      if (i % 6 == 3) begin #1; check("R8", predTaken8, |mHist8); end
      step(lbl);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule